// File: doc/BRIEF.md
# Bitmask Immediate Pattern Decoder

This block turns a packed 13-bit logical-immediate code into the full register-width bit mask it stands for. The code has three parts: a width-select bit, a 6-bit count field and a 6-bit rotation field. The count field, read together with the width-select bit, picks a power-of-two element size. Inside one element the decoder forms a run of consecutive ones starting at bit 0. It rotates that run right, inside the element only, and then tiles the element across a 32-bit or 64-bit destination.

The decoder is purely combinational and sits in an execute-stage operand path. Some codes are reserved. For those, and for a 64-bit element requested on a 32-bit destination, the decoder lowers its valid flag and drives an all-zero mask.

Top module: `bmi_decode`

## Requirements
- R1: When `wsel` is 1, the element is 64 bits wide. The whole of `cnt` gives S and the whole of `rot` gives R.
- R2: When `wsel` is 0, the element size comes from the most significant zero bit of `cnt`:
  - `cnt[5]`=0 gives 32.
  - otherwise `cnt[4]`=0 gives 16.
  - otherwise `cnt[3]`=0 gives 8.
  - otherwise `cnt[2]`=0 gives 4.
  - otherwise `cnt[1]`=0 gives 2.
- R3: Before rotation, an element of size E holds ones in bits 0..S and zeros above. S is `cnt` masked to its low log2(E) bits.
- R4: The run is rotated right by R modulo E, inside the element. R is `rot` masked to its low log2(E) bits, and the upper `rot` bits have no effect on the mask.
- R5: The element is repeated to fill the destination: 64 bits when `dw64`=1, 32 bits when `dw64`=0. In 32-bit mode `mask[63:32]` is always zero.
- R6: If the S bits that belong to the chosen element are all ones, `ok` is 0 and `mask` is zero.
- R7: If `wsel` is 0 and `cnt[5:1]` is 11111, `ok` is 0 and `mask` is zero.
- R8: If `wsel` is 1 and `dw64` is 0, `ok` is 0 and `mask` is zero.
- R9: A valid code never gives an all-zero mask or an all-ones destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wsel | input | 1 | Width-select bit of the code |
| cnt | input | 6 | Run-length field |
| rot | input | 6 | Rotation field |
| dw64 | input | 1 | Destination width: 1 = 64 bits, 0 = 32 bits |
| mask | output | 64 | Expanded mask, zero when invalid |
| ok | output | 1 | Code is legal for the selected width |

## Verification
The bench looks at several corner cases and what a faulty design would do in each:

- **Rotation across the whole word.** A design that rotated across the whole register instead of inside the element would spill bits between tiles once R is non-zero on small elements.
- **Unused `rot` bits.** A design that did not mask `rot` to the element's bits would rotate by too much.
- **Reserved codes.** The bench probes the all-ones run in every element size, the 11111x count patterns and a 64-bit element on a 32-bit destination. A decoder that missed any of these would return a dense or garbage mask with `ok` still set.
- **Exhaustive sweep.** A sweep of all 8192 codes in both widths also catches wrong tiling, such as upper bits left set in 32-bit mode.

// File: rtl/bmi_pkg.sv
package bmi_pkg;
    localparam int unsigned MASK_W  = 64;
    localparam int unsigned FIELD_W = $clog2(MASK_W);

    typedef struct packed {
        logic [FIELD_W-1:0] lvl;   // element size minus one
        logic               ok;    // an element size was found
    } elem_t;
endpackage

// File: rtl/bmi_elem_sel.sv
module bmi_elem_sel
    import bmi_pkg::*;
(
    input  logic               wsel,
    input  logic [FIELD_W-1:0] cnt,
    output elem_t              sel
);
    localparam int unsigned LEN_W = $clog2(FIELD_W + 1);

    logic [FIELD_W:0]   probe;
    logic [LEN_W-1:0]   len;
    logic               found;

    assign probe = {wsel, ~cnt};

    always_comb begin
        len   = '0;
        found = 1'b0;
        for (int k = 0; k <= FIELD_W; k++) begin
            if (probe[k]) begin
                len   = LEN_W'(k);
                found = 1'b1;
            end
        end
        for (int b = 0; b < FIELD_W; b++) begin
            sel.lvl[b] = (LEN_W'(b) < len);
        end
        sel.ok = found && (len != '0);
        AST_WIDE_ELEM: assert (!wsel || sel.lvl == '1) else $error("wide element not full size"); // R1
    end
endmodule

// File: rtl/bmi_run_rot.sv
module bmi_run_rot
    import bmi_pkg::*;
(
    input  logic [FIELD_W-1:0] lvl,
    input  logic [FIELD_W-1:0] cnt,
    input  logic [FIELD_W-1:0] rot,
    output logic [MASK_W-1:0]  elem,
    output logic               full
);
    logic [FIELD_W-1:0] s_eff;
    logic [FIELD_W-1:0] r_eff;

    assign s_eff = cnt & lvl;
    assign r_eff = rot & lvl;
    assign full  = (s_eff == lvl);

    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        localparam logic [FIELD_W-1:0] IDX = FIELD_W'(i);
        logic [FIELD_W-1:0] src;
        assign src     = (IDX + r_eff) & lvl;
        assign elem[i] = (IDX <= lvl) && (src <= s_eff);
    end
endmodule

// File: rtl/bmi_replicate.sv
module bmi_replicate
    import bmi_pkg::*;
(
    input  logic [MASK_W-1:0]  elem,
    input  logic [FIELD_W-1:0] lvl,
    input  logic               dw64,
    output logic [MASK_W-1:0]  tiled
);
    localparam int unsigned HALF = MASK_W / 2;

    for (genvar i = 0; i < MASK_W; i++) begin : g_tile
        localparam logic [FIELD_W-1:0] IDX = FIELD_W'(i);
        if (i < HALF) begin : g_lo
            assign tiled[i] = elem[IDX & lvl];
        end else begin : g_hi
            assign tiled[i] = dw64 && elem[IDX & lvl];
        end
    end
endmodule

// File: rtl/bmi_decode.sv
module bmi_decode
    import bmi_pkg::*;
(
    input  logic               wsel,
    input  logic [5:0]         cnt,
    input  logic [5:0]         rot,
    input  logic               dw64,
    output logic [63:0]        mask,
    output logic               ok
);
    localparam int unsigned HALF = MASK_W / 2;

    elem_t              sel;
    logic [MASK_W-1:0]  elem;
    logic [MASK_W-1:0]  tiled;
    logic               full;

    bmi_elem_sel u_sel (
        .wsel (wsel),
        .cnt  (cnt),
        .sel  (sel)
    );

    bmi_run_rot u_run (
        .lvl  (sel.lvl),
        .cnt  (cnt),
        .rot  (rot),
        .elem (elem),
        .full (full)
    );

    bmi_replicate u_rep (
        .elem  (elem),
        .lvl   (sel.lvl),
        .dw64  (dw64),
        .tiled (tiled)
    );

    always_comb begin
        ok   = sel.ok && !full && !(wsel && !dw64);
        mask = ok ? tiled : '0;
    end

    always_comb begin
        AST_INVALID_ZERO: assert (ok || mask == '0) else $error("invalid code leaks mask"); // R6
        AST_NARROW_UPPER: assert (dw64 || mask[MASK_W-1:HALF] == '0) else $error("upper half set"); // R5
        AST_NARROW_WIDE: assert (!(wsel && !dw64) || !ok) else $error("64-bit element on 32-bit"); // R8
        AST_RESERVED_CNT: assert (wsel || cnt[5:1] != 5'h1f || !ok) else $error("reserved count accepted"); // R7
        AST_VALID_NONZERO: assert (!ok || mask != '0) else $error("valid mask empty"); // R9
        AST_VALID_NOT_FULL: assert (!ok || (dw64 ? mask != '1 : mask[HALF-1:0] != '1)) else $error("valid mask full"); // R9
    end
endmodule

// File: tb/test_bmi_decode.sv
module test_bmi_decode;
    logic        clk = 1'b0;
    logic        wsel, dw64;
    logic [5:0]  cnt, rot;
    logic [63:0] mask;
    logic        ok;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #5 clk = ~clk;

    bmi_decode i_bmi_decode (
        .wsel (wsel), .cnt (cnt), .rot (rot), .dw64 (dw64),
        .mask (mask), .ok (ok)
    );

    // Independent reference model, built from the requirements.
    function automatic void model(input logic n, input logic [5:0] s, input logic [5:0] r,
                                  input logic w64, output logic [63:0] m, output logic v);
        int esize;
        int sv, rv, reg_w;
        logic [63:0] e;
        esize = 0;
        if (n)            esize = 64;
        else if (!s[5])   esize = 32;
        else if (!s[4])   esize = 16;
        else if (!s[3])   esize = 8;
        else if (!s[2])   esize = 4;
        else if (!s[1])   esize = 2;
        m = '0;
        v = 1'b0;
        if (esize == 0) return;
        if (n && !w64) return;
        sv = int'(s) % esize;
        rv = int'(r) % esize;
        if (sv == esize - 1) return;
        e = '0;
        for (int k = 0; k < esize; k++) begin
            if (((k + rv) % esize) <= sv) e[k] = 1'b1;
        end
        reg_w = w64 ? 64 : 32;
        for (int w = esize; w < reg_w; w = w * 2) e = e | (e << w);
        m = w64 ? e : {32'h0, e[31:0]};
        v = 1'b1;
    endfunction

    task automatic apply(input logic n, input logic [5:0] s, input logic [5:0] r, input logic w64);
        @(posedge clk);
        wsel = n; cnt = s; rot = r; dw64 = w64;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] em, input logic ev);
        n_chk++;
        if (mask !== em || ok !== ev) begin
            n_bad++;
            $display("FAIL %s: wsel=%0b cnt=%h rot=%h dw64=%0b got mask=%h ok=%0b expected mask=%h ok=%0b",
                     tag, wsel, cnt, rot, dw64, mask, ok, em, ev);
        end
    endtask

    task automatic run_one(input string tag, input logic n, input logic [5:0] s,
                           input logic [5:0] r, input logic w64);
        logic [63:0] em;
        logic ev;
        apply(n, s, r, w64);
        model(n, s, r, w64, em, ev);
        check(tag, em, ev);
    endtask

    task automatic t_idle;          // all-zero code: 32-bit element, single one
        apply(1'b0, 6'h00, 6'h00, 1'b1);
        check("R2 idle", 64'h0000_0001_0000_0001, 1'b1);
    endtask

    task automatic t_wide_elem;     // R1, R3
        apply(1'b1, 6'h07, 6'h00, 1'b1);
        check("R1 wide run", 64'h0000_0000_0000_00ff, 1'b1);
        apply(1'b1, 6'h00, 6'h01, 1'b1);
        check("R1 wide rot", 64'h8000_0000_0000_0000, 1'b1);
        apply(1'b1, 6'h3e, 6'h00, 1'b1);
        check("R3 wide long", 64'h7fff_ffff_ffff_ffff, 1'b1);
    endtask

    task automatic t_sizes;         // R2, R4, R5
        apply(1'b0, 6'h3c, 6'h00, 1'b1);
        check("R2 size2", 64'h5555_5555_5555_5555, 1'b1);
        apply(1'b0, 6'h3c, 6'h01, 1'b1);
        check("R4 size2 rot", 64'haaaa_aaaa_aaaa_aaaa, 1'b1);
        apply(1'b0, 6'h38, 6'h3d, 1'b1);
        check("R4 size4 high rot bits", 64'h8888_8888_8888_8888, 1'b1);
        apply(1'b0, 6'h32, 6'h00, 1'b0);
        check("R5 size8 narrow", 64'h0000_0000_0707_0707, 1'b1);
        apply(1'b0, 6'h20, 6'h31, 1'b1);
        check("R4 size16 rot", 64'h8000_8000_8000_8000, 1'b1);
    endtask

    task automatic t_reserved;      // R6, R7, R8
        apply(1'b0, 6'h1f, 6'h00, 1'b1);
        check("R6 full32", 64'h0, 1'b0);
        apply(1'b0, 6'h3b, 6'h02, 1'b1);
        check("R6 full4", 64'h0, 1'b0);
        apply(1'b1, 6'h3f, 6'h00, 1'b1);
        check("R6 full64", 64'h0, 1'b0);
        apply(1'b0, 6'h3e, 6'h00, 1'b1);
        check("R7 11111x", 64'h0, 1'b0);
        apply(1'b0, 6'h3f, 6'h05, 1'b0);
        check("R7 111111", 64'h0, 1'b0);
        apply(1'b1, 6'h00, 6'h00, 1'b0);
        check("R8 wide on narrow", 64'h0, 1'b0);
    endtask

    task automatic t_sweep;         // R3 R4 R5 R9 over every code
        for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 8192; c++) begin
                logic [12:0] code;
                code = 13'(c);
                run_one("R9 sweep", code[12], code[11:6], code[5:0], w[0]);
            end
        end
    endtask

    initial begin
        wsel = 1'b0; cnt = '0; rot = '0; dw64 = 1'b1;
        t_idle();
        t_wide_elem();
        t_sizes();
        t_reserved();
        t_sweep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(190000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule